// File: doc/BRIEF.md
# Result Dispatch and Method Sender

This block sits behind the execution stage of a small command-processing sequencer. Each accepted instruction presents a 32-bit result, a destination register index, a 3-bit routing code and, from the parameter stream, the next parameter word. The routing code selects one of eight fixed combinations of three actions:
- which value goes to the register file: the result or a fetched parameter;
- whether the result reloads the method-address register;
- what, if anything, is emitted as a method call.

The method-address register holds a 12-bit address and a 6-bit step. Each method call carries the current address and a data word. After every call, the address advances by the step, modulo 4096. Method calls leave through a valid/ready port. While a call is waiting and the consumer is not ready, the block stalls the sequencer. Register writes leave through a registered write port one cycle after acceptance.

Top module: `result_router`

## Requirements
- R1: Code 0 writes the fetched parameter to the destination register and sends nothing; the method address is unchanged.
- R2: Code 1 writes the result to the destination register and sends nothing.
- R3: Code 2 writes the result to the destination and loads the method-address register from it: address = result[11:0], step = result[17:12].
- R4: Code 3 writes the fetched parameter to the destination and sends the result at the current method address.
- R5: Code 4 writes the result to the destination and sends the result at the current method address.
- R6: Code 5 writes the fetched parameter to the destination and loads the method-address register from the result (same fields as R3).
- R7: Code 6 writes the result to the destination, loads the method-address register from it, and sends the fetched parameter at the newly loaded address.
- R8: Code 7 writes the result to the destination, loads the method-address register from it, and sends result[17:12], zero-extended, at the newly loaded address.
- R9: After every send, the address field becomes the address sent plus the step, modulo 4096.
- R10: While a call is pending and `call_ready` is low, `stall` is high. The pending call's address and data hold steady. No instruction is accepted, so no register write follows and `param_take` stays low.
- R11: After reset, `rf_we` and `call_valid` are low and the method address and step are zero.
- R12: `param_take` is high exactly in a cycle where an instruction is accepted (`op_valid` high, `stall` low) with code 0, 3, 5 or 6.
- R13: An accepted instruction produces `rf_we` with its destination and data on the next cycle. A send produces `call_valid` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction result presented |
| op_code | input | 3 | Routing code |
| op_dst | input | 4 | Destination register index |
| op_result | input | 32 | Instruction result |
| param_data | input | 32 | Next parameter word from the stream |
| param_take | output | 1 | Parameter word consumed this cycle |
| stall | output | 1 | Sequencer must hold its instruction |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| call_valid | output | 1 | Method call pending |
| call_ready | input | 1 | Consumer accepts the call |
| call_addr | output | 12 | Method address of the call |
| call_data | output | 32 | Data of the call |

## Verification
Every routing code is driven with distinct result and parameter words. The written and sent values therefore show whether the result or the parameter was routed to each place. Sends follow address reloads with non-zero steps and back-to-back sends, which distinguishes using the old address from using the new one. A step that crosses 4095 exposes missing wrap-around. A period with the consumer not ready confirms that a waiting call holds and that no instruction slips through while the block stalls.

// File: rtl/result_router_pkg.sv
package result_router_pkg;
  typedef enum logic [2:0] {
    RC_FETCH_DROP   = 3'd0,
    RC_MOVE         = 3'd1,
    RC_MOVE_LOAD    = 3'd2,
    RC_FETCH_SEND   = 3'd3,
    RC_MOVE_SEND    = 3'd4,
    RC_FETCH_LOAD   = 3'd5,
    RC_LOAD_SENDPRM = 3'd6,
    RC_LOAD_SENDSTP = 3'd7
  } route_code_e;

  typedef enum logic [1:0] {
    SD_RESULT = 2'd0,
    SD_PARAM  = 2'd1,
    SD_STEP   = 2'd2
  } send_src_e;

  typedef struct packed {
    logic      fetch;
    logic      wr_param;
    logic      load;
    logic      send;
    send_src_e src;
  } route_t;
endpackage

// File: rtl/route_decode.sv
module route_decode
  import result_router_pkg::*;
(
  input  logic [2:0] code,
  output route_t     route
);
  always_comb begin
    route = '{fetch: 1'b0, wr_param: 1'b0, load: 1'b0, send: 1'b0, src: SD_RESULT};
    unique case (route_code_e'(code))
      RC_FETCH_DROP:   begin route.fetch = 1'b1; route.wr_param = 1'b1; end
      RC_MOVE:         ;
      RC_MOVE_LOAD:    route.load = 1'b1;
      RC_FETCH_SEND:   begin route.fetch = 1'b1; route.wr_param = 1'b1; route.send = 1'b1; end
      RC_MOVE_SEND:    route.send = 1'b1;
      RC_FETCH_LOAD:   begin route.fetch = 1'b1; route.wr_param = 1'b1; route.load = 1'b1; end
      RC_LOAD_SENDPRM: begin route.fetch = 1'b1; route.load = 1'b1; route.send = 1'b1;
                             route.src = SD_PARAM; end
      RC_LOAD_SENDSTP: begin route.load = 1'b1; route.send = 1'b1; route.src = SD_STEP; end
      default:         ;
    endcase
  end
endmodule

// File: rtl/method_addr_reg.sv
module method_addr_reg #(
  parameter int ADDR_W = 12,
  parameter int STEP_W = 6,
  localparam int WORD_W = ADDR_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              send,
  output logic [ADDR_W-1:0] send_addr
);
  logic [ADDR_W-1:0] addr_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_eff;

  assign send_addr = load ? load_word[ADDR_W-1:0] : addr_q;
  assign step_eff  = load ? load_word[WORD_W-1:ADDR_W] : step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      step_q <= '0;
    end else if (load || send) begin
      addr_q <= send ? send_addr + ADDR_W'(step_eff) : send_addr;
      step_q <= step_eff;
    end
  end
endmodule

// File: rtl/call_out_reg.sv
module call_out_reg #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              busy
);
  assign busy = valid && !ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= addr_in;
      data  <= data_in;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/result_router.sv
module result_router
  import result_router_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int STEP_W = 6,
  parameter int REG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [REG_W-1:0]  op_dst,
  input  logic [DATA_W-1:0] op_result,
  input  logic [DATA_W-1:0] param_data,
  output logic              param_take,
  output logic              stall,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              call_valid,
  input  logic              call_ready,
  output logic [ADDR_W-1:0] call_addr,
  output logic [DATA_W-1:0] call_data
);
  localparam int WORD_W = ADDR_W + STEP_W;

  route_t            route;
  logic              accept;
  logic [ADDR_W-1:0] send_addr;
  logic [DATA_W-1:0] send_data;

  route_decode u_dec (.code(op_code), .route(route));

  assign accept     = op_valid && !stall;
  assign param_take = accept && route.fetch;

  always_comb begin
    unique case (route.src)
      SD_PARAM: send_data = param_data;
      SD_STEP:  send_data = DATA_W'(op_result[WORD_W-1:ADDR_W]);
      default:  send_data = op_result;
    endcase
  end

  method_addr_reg #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_maddr (
    .clk(clk), .rst(rst),
    .load(accept && route.load),
    .load_word(op_result[WORD_W-1:0]),
    .send(accept && route.send),
    .send_addr(send_addr)
  );

  call_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_call (
    .clk(clk), .rst(rst),
    .load(accept && route.send),
    .addr_in(send_addr), .data_in(send_data),
    .ready(call_ready),
    .valid(call_valid), .addr(call_addr), .data(call_data),
    .busy(stall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
    end else begin
      rf_we <= accept;
      if (accept) begin
        rf_waddr <= op_dst;
        rf_wdata <= route.wr_param ? param_data : op_result;
      end
    end
  end
endmodule

// File: rtl/result_router_chk.sv
module result_router_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int STEP_W = 6,
  parameter int REG_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [DATA_W-1:0] op_result,
  input logic              param_take,
  input logic              stall,
  input logic              rf_we,
  input logic [DATA_W-1:0] rf_wdata,
  input logic              call_valid,
  input logic              call_ready,
  input logic [ADDR_W-1:0] call_addr,
  input logic [DATA_W-1:0] call_data
);
  // R10
  held_call_chk: assert property (@(posedge clk) disable iff (rst)
    (call_valid && !call_ready) |=> (call_valid && $stable(call_addr) && $stable(call_data)));
  // R10
  no_write_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !rf_we);
  // R12
  take_needs_accept_chk: assert property (@(posedge clk) disable iff (rst)
    param_take |-> (op_valid && !stall));
  // R5
  move_send_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !stall && op_code == 3'd4) |=>
      (call_valid && call_data == $past(op_result) && rf_we && rf_wdata == $past(op_result)));
  // R8
  step_field_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !stall && op_code == 3'd7) |=>
      (call_valid && call_data[DATA_W-1:STEP_W] == '0));
endmodule

bind result_router result_router_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STEP_W(STEP_W), .REG_W(REG_W)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_result(op_result),
  .param_take(param_take), .stall(stall), .rf_we(rf_we), .rf_wdata(rf_wdata),
  .call_valid(call_valid), .call_ready(call_ready), .call_addr(call_addr), .call_data(call_data)
);

// File: tb/result_router_test.sv
module result_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [3:0]  op_dst = '0;
  logic [31:0] op_result = '0;
  logic [31:0] param_data = '0;
  logic        call_ready = 1'b1;
  logic        param_take, stall, rf_we, call_valid;
  logic [3:0]  rf_waddr;
  logic [31:0] rf_wdata, call_data;
  logic [11:0] call_addr;

  int checks = 0;
  int fails  = 0;

  logic [11:0] m_addr = '0;
  logic [5:0]  m_step = '0;

  logic [35:0] rf_q[$];
  string       rf_tag[$];
  logic [43:0] snd_q[$];
  string       snd_tag[$];

  always #4 clk = ~clk;

  result_router uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_dst(op_dst),
    .op_result(op_result), .param_data(param_data), .param_take(param_take), .stall(stall),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .call_valid(call_valid),
    .call_ready(call_ready), .call_addr(call_addr), .call_data(call_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare design outputs with the scoreboard queues
  always @(negedge clk) begin
    if (!rst && rf_we) begin
      if (rf_q.size() == 0) check(1'b0, "R13 unexpected write", {28'd0, rf_waddr, rf_wdata}, 0);
      else begin
        logic [35:0] e;
        string t;
        e = rf_q.pop_front(); t = rf_tag.pop_front();
        check({rf_waddr, rf_wdata} == e, t, {28'd0, rf_waddr, rf_wdata}, {28'd0, e});
      end
    end
    if (!rst && call_valid && call_ready) begin
      if (snd_q.size() == 0) check(1'b0, "R13 unexpected call", {20'd0, call_addr, call_data}, 0);
      else begin
        logic [43:0] e;
        string t;
        e = snd_q.pop_front(); t = snd_tag.pop_front();
        check({call_addr, call_data} == e, t, {20'd0, call_addr, call_data}, {20'd0, e});
      end
    end
  end

  // driver: compute expectations from the requirements and present the instruction
  task automatic issue(input logic [2:0] code, input logic [3:0] dst,
                       input logic [31:0] res, input logic [31:0] prm, input string tag);
    bit fetch, wparam, load, send;
    logic [31:0] sdata;
    logic [11:0] saddr;
    fetch  = (code == 0) || (code == 3) || (code == 5) || (code == 6);
    wparam = (code == 0) || (code == 3) || (code == 5);
    load   = (code == 2) || (code == 5) || (code == 6) || (code == 7);
    send   = (code == 3) || (code == 4) || (code == 6) || (code == 7);
    sdata  = (code == 6) ? prm : (code == 7) ? {26'd0, res[17:12]} : res;
    if (load) begin m_addr = res[11:0]; m_step = res[17:12]; end
    saddr = m_addr;
    if (send) m_addr = m_addr + {6'd0, m_step};
    rf_q.push_back({dst, wparam ? prm : res}); rf_tag.push_back({tag, " write"});
    if (send) begin snd_q.push_back({saddr, sdata}); snd_tag.push_back({tag, " call"}); end
    @(negedge clk);
    while (stall) @(negedge clk);
    op_valid = 1'b1; op_code = code; op_dst = dst; op_result = res; param_data = prm;
    #1;
    check(param_take == fetch, "R12 param_take", {63'd0, param_take}, {63'd0, fetch});
    @(posedge clk);
    #1 op_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!rf_we && !call_valid && !stall, "R11 reset outputs", {61'd0, rf_we, call_valid, stall}, 0);
    // R11: address zero after reset, observed by a plain send
    issue(3'd4, 4'd1, 32'h1111_0000, 32'hBAD0_0001, "R11/R5 code4");
    issue(3'd0, 4'd2, 32'hDEAD_0002, 32'h0000_A5A5, "R1 code0");
    issue(3'd4, 4'd3, 32'h2222_0003, 32'hBAD0_0003, "R1 addr kept");
    issue(3'd1, 4'd4, 32'h3333_0004, 32'hBAD0_0004, "R2 code1");
    issue(3'd2, 4'd5, 32'h0000_5123, 32'hBAD0_0005, "R3 code2");
    issue(3'd4, 4'd6, 32'h4444_0006, 32'hBAD0_0006, "R3/R9 send at loaded");
    issue(3'd3, 4'd7, 32'h5555_0007, 32'h0000_7777, "R4/R9 code3");
    issue(3'd5, 4'd8, 32'h0002_0400, 32'h0000_8888, "R6 code5");
    issue(3'd4, 4'd9, 32'h6666_0009, 32'hBAD0_0009, "R6 send at loaded");
    issue(3'd6, 4'hA, 32'h0001_0700, 32'h0000_ABCD, "R7 code6");
    issue(3'd4, 4'hB, 32'h7777_000B, 32'hBAD0_000B, "R7/R9 after code6");
    issue(3'd7, 4'hC, 32'hFFF2_B080, 32'hBAD0_000C, "R8 code7");
    // R9 wrap: address 0xFFE step 3
    issue(3'd2, 4'hD, 32'h0000_3FFE, 32'hBAD0_000D, "R9 load near top");
    issue(3'd4, 4'hE, 32'h8888_000E, 32'hBAD0_000E, "R9 wrap send1");
    issue(3'd4, 4'hF, 32'h9999_000F, 32'hBAD0_000F, "R9 wrap send2");
    // R10 stall
    @(posedge clk); #1 call_ready = 1'b0;
    issue(3'd4, 4'd1, 32'hCAFE_0010, 32'hBAD0_0010, "R10 held call");
    @(negedge clk);
    check(stall == 1'b1, "R10 stall high", {63'd0, stall}, 1);
    op_valid = 1'b1; op_code = 3'd0; op_dst = 4'd2; op_result = 32'h1; param_data = 32'h2;
    #1 check(param_take == 1'b0, "R10 no take in stall", {63'd0, param_take}, 0);
    repeat (3) @(negedge clk);
    check(stall && call_valid && call_addr == m_addr - 12'd3 && call_data == 32'hCAFE_0010,
          "R10 call held", {20'd0, call_addr, call_data}, {20'd0, m_addr - 12'd3, 32'hCAFE_0010});
    op_valid = 1'b0;
    @(posedge clk); #1 call_ready = 1'b1;
    issue(3'd1, 4'd3, 32'h0BAD_F00D, 32'hBAD0_0011, "R10 resume");
    repeat (4) @(negedge clk);
    check(rf_q.size() == 0 && snd_q.size() == 0, "R13 all drained",
          64'(rf_q.size() + snd_q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule